// File: doc/BRIEF.md
# Monochrome Pixel Readout Formatter

This block walks the pixel array of a monochrome image sensor in raster order and turns the two digitized samples taken for each pixel into one 8-bit output word. Each scan position comes with a reference sample and a signal sample. A two-bit data-type selector chooses what is sent out: the correlated-double-sampling difference (signal minus reference, floored at zero), the reference sample alone, or the signal sample alone.

The full scan covers a total area. Only a smaller effective window inside it is flagged valid, and its placement is set by column and row start offsets. Offsets that would push the window past the array edge are pulled back so the window fits. Line timing comes out on a horizontal sync pin in one of two styles: a level that is high through the valid part of each line, or a gated copy of the pixel clock that can serve as a data strobe. A vertical sync marks the first line of every frame. The scan only advances under a filtered enable. An active-low reset only takes effect after a minimum hold time, so short glitches cannot disturb the scan.

Top module: `pixel_readout_formatter`

## Requirements
- R1: When `rst_n` is sampled low on 8 consecutive rising edges, the next edge clears the scan position to column 0, row 0 and drives `data_valid`, `pixel_out` and `vsync` low. A low pulse seen on fewer than 8 edges changes nothing.
- R2: The scan advances on a rising edge only if `enable` was sampled high on that edge and on the one before. On any other edge the position is held and `data_valid` and `pixel_out` are 0.
- R3: Each qualified edge steps the column. After column COLS_TOTAL-1 the column returns to 0 and the row steps. After the last row the frame starts again at row 0.
- R4: `data_valid` rises one edge after a qualified step at a position with column in [cs, cs+COLS_VALID) and row in [rs, rs+ROWS_VALID). cs and rs are the effective start offsets. Exactly COLS_VALID*ROWS_VALID valid words appear per frame.
- R5: A column start above COLS_TOTAL-COLS_VALID acts as COLS_TOTAL-COLS_VALID. A row start above ROWS_TOTAL-ROWS_VALID acts as ROWS_TOTAL-ROWS_VALID.
- R6: Data-type code 2'b00 outputs the signal sample minus the reference sample, and outputs 0 when the reference is larger. Code 2'b11 behaves exactly like 2'b00.
- R7: Code 2'b01 outputs the reference sample. Code 2'b10 outputs the signal sample.
- R8: `pixel_out` is 0 whenever `data_valid` is 0.
- R9: With the registered hsync mode at 0, `hsync` equals `data_valid` in both clock phases.
- R10: With the registered hsync mode at 1, `hsync` equals `data_valid` while `clk` is high and is 0 while `clk` is low.
- R11: On each qualified step `vsync` is loaded with (row == 0). It holds its value between steps, so it stays high for one whole line at the top of each frame.
- R12: `data_type` and `hsync_mode` are captured on every edge outside reset and forced to 2'b00 and 0 during reset. A word produced on an edge uses the mode captured on the edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, filtered by hold time |
| enable | input | 1 | Scan enable, qualified by hold time |
| ref_sample | input | 8 | Digitized reference level of the current position |
| sig_sample | input | 8 | Digitized signal level of the current position |
| data_type | input | 2 | Output selector: 00 difference, 01 reference, 10 signal, 11 as 00 |
| hsync_mode | input | 1 | 0: level sync, 1: clock-gated sync |
| col_start | input | $clog2(COLS_TOTAL) | Requested first valid column |
| row_start | input | $clog2(ROWS_TOTAL) | Requested first valid row |
| pixel_out | output | 8 | Formatted pixel word |
| data_valid | output | 1 | High for words inside the effective window |
| hsync | output | 1 | Line sync in the selected style |
| vsync | output | 1 | High during the first line of each frame |

## Verification
On every clock the assertions check that an idle output carries a zero word, that an unqualified edge leaves the scan position untouched, that a valid word only follows a qualified step, that the frame wraps from its last position to the origin, that a floored difference never wraps, and that a step on row 0 raises vsync. The bench's scenarios are needed for everything that depends on history or on the clock phase. That covers the reset hold count, the one-cycle enable pulse being ignored, the window count per frame and its clamped placement, the one-edge lag of a mode change, and the shape of hsync in the low phase of the clock.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic [1:0] {
    DT_DIFF = 2'b00,
    DT_REF  = 2'b01,
    DT_SIG  = 2'b10,
    DT_RSVD = 2'b11
  } dtype_e;

  // signal minus reference, floored at zero
  function automatic pix_t sat_diff(pix_t s, pix_t r);
    return (s > r) ? pix_t'(s - r) : '0;
  endfunction

  function automatic pix_t pick_sample(dtype_e t, pix_t r, pix_t s);
    case (t)
      DT_REF:  return r;
      DT_SIG:  return s;
      default: return sat_diff(s, r);
    endcase
  endfunction

  function automatic int unsigned clamp_start(int unsigned req, int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/prf_rst_filter.sv
module prf_rst_filter #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_rst
);
  // last HOLD sampled levels of rst_n; reset only when all were low
  logic [HOLD-1:0] hist;

  always_ff @(posedge clk) begin
    hist <= {hist[HOLD-2:0], rst_n};
  end

  assign sync_rst = ~|hist;
endmodule

// File: rtl/prf_enable_qual.sv
module prf_enable_qual #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic sync_rst,
  input  logic enable,
  output logic step
);
  logic [HOLD-2:0] hist;
  logic [HOLD-1:0] wide;

  assign wide = {hist, enable};
  assign step = &wide;

  always_ff @(posedge clk) begin
    if (sync_rst) hist <= '0;
    else          hist <= wide[HOLD-2:0];
  end

  // R2: a step needs enable on the previous edge as well
  assert_step_needs_history_R2: assert property (@(posedge clk) disable iff (sync_rst)
    step |-> $past(enable));
endmodule

// File: rtl/prf_scan.sv
module prf_scan #(
  parameter int COLS = 414,
  parameter int ROWS = 314,
  parameter int CW   = $clog2(COLS),
  parameter int RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          sync_rst,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row
);
  logic line_last, frame_last;

  assign line_last  = (col == CW'(COLS - 1));
  assign frame_last = (row == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (line_last) begin
        col <= '0;
        row <= frame_last ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  // R2: position frozen on unqualified edges
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (sync_rst)
    !step |=> ($stable(col) && $stable(row)));
  // R3: last position of a frame returns to the origin
  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (sync_rst)
    (step && line_last && frame_last) |=> (col == '0 && row == '0));
  // R3: column never leaves the array
  assert_col_range_R3: assert property (@(posedge clk) disable iff (sync_rst)
    32'(col) < COLS);
endmodule

// File: rtl/prf_out_stage.sv
module prf_out_stage
  import prf_pkg::*;
#(
  parameter int COLS  = 414,
  parameter int ROWS  = 314,
  parameter int VCOLS = 400,
  parameter int VROWS = 300,
  parameter int CW    = $clog2(COLS),
  parameter int RW    = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          sync_rst,
  input  logic          step,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col_start,
  input  logic [RW-1:0] row_start,
  input  pix_t          ref_s,
  input  pix_t          sig_s,
  input  logic [1:0]    dtype_in,
  input  logic          hsm_in,
  output pix_t          pix,
  output logic          dv,
  output logic          vs,
  output logic          hsm_q
);
  localparam int unsigned COL_LIM = COLS - VCOLS;
  localparam int unsigned ROW_LIM = ROWS - VROWS;

  dtype_e      dtype_q;
  pix_t        cds_val;
  logic        in_window;
  logic [31:0] eff_cs, eff_rs, c32, r32;

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      dtype_q <= DT_DIFF;
      hsm_q   <= 1'b0;
    end else begin
      dtype_q <= dtype_e'(dtype_in);
      hsm_q   <= hsm_in;
    end
  end

  assign eff_cs    = clamp_start(32'(col_start), COL_LIM);
  assign eff_rs    = clamp_start(32'(row_start), ROW_LIM);
  assign c32       = 32'(col);
  assign r32       = 32'(row);
  assign in_window = (c32 >= eff_cs) && (c32 < eff_cs + VCOLS) &&
                     (r32 >= eff_rs) && (r32 < eff_rs + VROWS);
  assign cds_val   = pick_sample(dtype_q, ref_s, sig_s);

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      dv  <= 1'b0;
      pix <= '0;
      vs  <= 1'b0;
    end else if (step) begin
      dv  <= in_window;
      pix <= in_window ? cds_val : '0;
      vs  <= (row == '0);
    end else begin
      dv  <= 1'b0;
      pix <= '0;
    end
  end

  // R8: idle cycles carry a zero word
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (sync_rst)
    !dv |-> (pix == '0));
  // R6: the floored difference never wraps
  assert_diff_floor_R6: assert property (@(posedge clk) disable iff (sync_rst)
    ((dtype_q == DT_DIFF || dtype_q == DT_RSVD) && ref_s > sig_s) |-> (cds_val == '0));
  // R4: a valid word only follows a qualified step
  assert_valid_after_step_R4: assert property (@(posedge clk) disable iff (sync_rst)
    dv |-> $past(step));
endmodule

// File: rtl/pixel_readout_formatter.sv
module pixel_readout_formatter
  import prf_pkg::*;
#(
  parameter int COLS_TOTAL = 414,
  parameter int ROWS_TOTAL = 314,
  parameter int COLS_VALID = 400,
  parameter int ROWS_VALID = 300,
  parameter int RST_HOLD   = 8,
  parameter int EN_HOLD    = 2,
  localparam int CW = $clog2(COLS_TOTAL),
  localparam int RW = $clog2(ROWS_TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PIX_W-1:0] ref_sample,
  input  logic [PIX_W-1:0] sig_sample,
  input  logic [1:0]       data_type,
  input  logic             hsync_mode,
  input  logic [CW-1:0]    col_start,
  input  logic [RW-1:0]    row_start,
  output logic [PIX_W-1:0] pixel_out,
  output logic             data_valid,
  output logic             hsync,
  output logic             vsync
);
  logic          sync_rst;
  logic          step;
  logic          hsm_q;
  logic [CW-1:0] col;
  logic [RW-1:0] row;

  prf_rst_filter #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst));

  prf_enable_qual #(.HOLD(EN_HOLD)) u_en (
    .clk(clk), .sync_rst(sync_rst), .enable(enable), .step(step));

  prf_scan #(.COLS(COLS_TOTAL), .ROWS(ROWS_TOTAL), .CW(CW), .RW(RW)) u_scan (
    .clk(clk), .sync_rst(sync_rst), .step(step), .col(col), .row(row));

  prf_out_stage #(
    .COLS(COLS_TOTAL), .ROWS(ROWS_TOTAL), .VCOLS(COLS_VALID), .VROWS(ROWS_VALID),
    .CW(CW), .RW(RW)
  ) u_out (
    .clk(clk), .sync_rst(sync_rst), .step(step), .col(col), .row(row),
    .col_start(col_start), .row_start(row_start),
    .ref_s(ref_sample), .sig_s(sig_sample),
    .dtype_in(data_type), .hsm_in(hsync_mode),
    .pix(pixel_out), .dv(data_valid), .vs(vsync), .hsm_q(hsm_q));

  // level style or pixel-clock strobe style
  assign hsync = hsm_q ? (clk & data_valid) : data_valid;

  // R11: a step on the top row raises vsync
  assert_vsync_top_row_R11: assert property (@(posedge clk) disable iff (sync_rst)
    (step && row == '0) |=> vsync);
endmodule

// File: tb/sim_pixel_readout_formatter.sv
module sim_pixel_readout_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int CT = 12, RT = 7, CV = 8, RV = 4;
  localparam int CW = $clog2(CT), RW = $clog2(RT);

  logic clk = 1'b0;
  logic rst_n = 1'b0, enable = 1'b0, hsync_mode = 1'b0;
  logic [7:0] ref_s = '0, sig_s = '0;
  logic [1:0] data_type = 2'b00;
  logic [CW-1:0] col_start = '0;
  logic [RW-1:0] row_start = '0;
  logic [7:0] pixel_out;
  logic data_valid, hsync, vsync;

  int n_checks = 0, n_fail = 0, sc = 0;
  int m_low = 0, m_k = 0, m_dtype = 0, m_pix = 0;
  bit m_armed = 0, m_en_prev = 0, m_hsm = 0, m_dv = 0, m_vs = 0;
  int cnt_dv = 0, cnt_vs = 0;
  string ptag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_readout_formatter #(.COLS_TOTAL(CT), .ROWS_TOTAL(RT),
    .COLS_VALID(CV), .ROWS_VALID(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ref_sample(ref_s), .sig_sample(sig_s),
    .data_type(data_type), .hsync_mode(hsync_mode), .col_start(col_start),
    .row_start(row_start), .pixel_out(pixel_out), .data_valid(data_valid),
    .hsync(hsync), .vsync(vsync));

  function automatic int expect_pix(int t, int r, int s);
    if (t == 1) return r;
    if (t == 2) return s;
    return (s >= r) ? s - r : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive samples, model the edge, compare in both clock phases
  task automatic tick();
    int col, row, ecs, ers;
    bit inwin;
    string tag;
    sc++;
    ref_s = 8'(sc * 29 + 3);
    sig_s = 8'(sc * 71 + 200);
    @(posedge clk);
    tag = (m_dtype == 1 || m_dtype == 2) ? "R7" : "R6";
    if (ptag != "") tag = ptag;
    if (m_low >= 8) begin
      m_k = 0; m_dv = 0; m_pix = 0; m_vs = 0; m_dtype = 0; m_hsm = 0;
      m_en_prev = 0; m_armed = 1;
    end else begin
      if (enable && m_en_prev) begin
        col = m_k % CT; row = m_k / CT;
        ecs = (int'(col_start) > CT - CV) ? CT - CV : int'(col_start);
        ers = (int'(row_start) > RT - RV) ? RT - RV : int'(row_start);
        inwin = (col >= ecs) && (col < ecs + CV) && (row >= ers) && (row < ers + RV);
        m_dv = inwin;
        m_pix = inwin ? expect_pix(m_dtype, int'(ref_s), int'(sig_s)) : 0;
        m_vs = (row == 0);
        m_k = (m_k + 1) % (CT * RT);
      end else begin
        m_dv = 0; m_pix = 0;
      end
      m_en_prev = enable; m_dtype = int'(data_type); m_hsm = hsync_mode;
    end
    m_low = rst_n ? 0 : m_low + 1;
    #(CLK_PERIOD/5);
    if (m_armed) begin
      chk("R4 data_valid", int'(data_valid), int'(m_dv));
      if (!m_dv) chk("R8 idle word", int'(pixel_out), 0);
      else       chk({tag, " pixel"}, int'(pixel_out), m_pix);
      chk("R11 vsync", int'(vsync), int'(m_vs));
      chk("R9 hsync high phase", int'(hsync), int'(m_dv));
      cnt_dv += int'(data_valid);
      cnt_vs += int'(vsync);
    end
    #(CLK_PERIOD/2);
    if (m_armed) begin
      if (m_hsm) chk("R10 hsync low phase", int'(hsync), 0);
      else       chk("R9 hsync low phase", int'(hsync), int'(m_dv));
    end
  endtask

  task automatic reset_seq();
    rst_n = 1'b0; enable = 1'b0;
    for (int i = 0; i < 10; i++) tick();
    rst_n = 1'b1; enable = 1'b1;
    tick();
    chk("R1 reset data_valid", int'(data_valid), 0);
    chk("R1 reset vsync", int'(vsync), 0);
    chk("R1 reset pixel", int'(pixel_out), 0);
    tick();
  endtask

  task automatic t_full_frame();
    data_type = 2'b00; hsync_mode = 1'b0; col_start = 2; row_start = 1;
    reset_seq();
    cnt_dv = 0; cnt_vs = 0;
    for (int i = 0; i < CT * RT; i++) tick();
    chk("R4 valid words per frame", cnt_dv, CV * RV);
    chk("R11 vsync line length", cnt_vs, CT);
    tick();
    chk("R3 frame wrap raises vsync", int'(vsync), 1);
  endtask

  task automatic t_modes();
    hsync_mode = 1'b1; col_start = 0; row_start = 0;
    reset_seq();
    for (int t = 1; t < 4; t++) begin
      data_type = 2'(t);
      ptag = "R12";
      tick();
      ptag = "";
      for (int i = 0; i < 20; i++) tick();
    end
    hsync_mode = 1'b0;
    tick();
    data_type = 2'b00;
    for (int i = 0; i < 20; i++) tick();
  endtask

  task automatic t_clamp();
    data_type = 2'b10; hsync_mode = 1'b0; col_start = 15; row_start = 7;
    reset_seq();
    cnt_dv = 0;
    for (int i = 0; i < CT * RT; i++) tick();
    chk("R5 clamped window count", cnt_dv, CV * RV);
  endtask

  task automatic t_enable();
    data_type = 2'b00; col_start = 0; row_start = 0;
    reset_seq();
    enable = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    cnt_dv = 0;
    enable = 1'b1; tick();
    enable = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    chk("R2 single-cycle enable ignored", cnt_dv, 0);
    enable = 1'b1;
    for (int i = 0; i < 30; i++) tick();
    enable = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    chk("R2 paused data_valid", int'(data_valid), 0);
    enable = 1'b1;
    for (int i = 0; i < 40; i++) tick();
  endtask

  task automatic t_short_reset();
    data_type = 2'b00; col_start = 1; row_start = 2;
    reset_seq();
    for (int i = 0; i < 40; i++) tick();
    cnt_dv = 0;
    rst_n = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk("R1 short low pulse keeps scanning", int'(cnt_dv > 0), 1);
    rst_n = 1'b0;
    for (int i = 0; i < 9; i++) tick();
    chk("R1 long low pulse clears outputs", int'(data_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_full_frame();
    t_modes();
    t_clamp();
    t_enable();
    t_short_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule